// File: doc/BRIEF.md
# Power-Up Strap Capture and Clock Enable Sequencer

This block brings a clock generator from power-on to running outputs. After a synchronous power-on reset it idles until an active-low, level-sensitive power-good strobe is seen low. On that first low level it captures three strap inputs exactly once: a two-level CPU frequency select, a three-level mode select that arrives already decoded into a two-bit level code, and a current-multiplier select. After that it never looks at the strobe or the straps again until the next reset.

Once the straps are held, the block turns on the VCO. It waits a configurable number of lock cycles and then enables the clock outputs. From the captured straps it derives the operating mode. In the normal modes, the CPU select chooses 100 MHz or 133 MHz and the mode level chooses the internal VCO or the external 66 MHz input as the source of the 66 MHz and PCI groups. The middle mode level selects one of two test modes. One floats every output. The other passes an external test clock through fixed per-group dividers.

A small synchronizer sits on the strobe. The straps are sampled on the same clock edge on which the synchronized strobe is first seen low, while the strobe is still low and the straps are therefore valid.

Top module: `clkgen_powerup_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `vco_en`, `out_en` and `straps_valid` at 0 and `op_mode` at 0 (no mode). All dividers are 0 and `out_hiz`, `ext66_src` and `cpu_133` are 0.
- R2: While `pwrgd_n` stays high after reset, the block keeps waiting. `straps_valid`, `vco_en` and `out_en` remain 0.
- R3: Count the clock edges from the first edge that samples `pwrgd_n` low, starting at 1. The edge numbered `SYNC_STAGES`+1 latches `cpu_sel`, `mode_lvl` and `mult_sel` into `cpu_sel_q`, `mode_lvl_q` and `mult_q` and sets `straps_valid`. The strap values present at that edge are the ones held.
- R4: After capture, later changes on `pwrgd_n` (high, then low again) and on the strap inputs leave the held straps, `op_mode`, `vco_en` and `out_en` unchanged until reset.
- R5: `vco_en` rises one clock after capture and stays high.
- R6: `out_en` rises exactly `LOCK_CYCLES` clocks after `vco_en` rises. `out_en` is never high while `vco_en` is low.
- R7: Normal modes, where level code 2'b00 is low and 2'b10 is high. Low with CPU select 0 gives `op_mode`=1 (internal VCO, 100 MHz), and low with CPU select 1 gives `op_mode`=2 (133 MHz). High gives 3 or 4 in the same way, with `ext66_src`=1. `cpu_133` equals the CPU select. The decoded outputs become valid in the same cycle as `vco_en`.
- R8: Level code 2'b01 (middle) with CPU select 0 gives `op_mode`=5 and `out_hiz`=1, with all dividers 0.
- R9: Middle level with CPU select 1 gives `op_mode`=6 (test clock). The dividers are CPU 2, 66 MHz groups 4, PCI 8, USB/DOT 2 and reference 1, with `out_hiz`=0, `ext66_src`=0 and `cpu_133`=0.
- R10: Level code 2'b11 decodes exactly as the middle level.
- R11: A reset during the lock wait returns the block to waiting with all enables low. With the strobe held high after that reset, nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pwrgd_n | input | 1 | Power-good strobe, active low, level sensitive |
| cpu_sel | input | 1 | CPU frequency select strap |
| mode_lvl | input | 2 | Mode select level code: 00 low, 01 mid, 10 high, 11 treated as mid |
| mult_sel | input | 1 | Current-multiplier select strap |
| cpu_sel_q | output | 1 | Held CPU select |
| mode_lvl_q | output | 2 | Held mode level code |
| mult_q | output | 1 | Held multiplier select |
| straps_valid | output | 1 | Straps have been captured |
| op_mode | output | 3 | Decoded operating mode (0 none, 1..6 as in R7 to R9) |
| cpu_133 | output | 1 | Normal mode at 133 MHz CPU |
| ext66_src | output | 1 | 66 MHz buffers and PCI taken from the external 66 MHz input |
| out_hiz | output | 1 | All outputs floated |
| div_cpu | output | DIV_W | Test-clock divider for CPU outputs |
| div_66 | output | DIV_W | Test-clock divider for 66 MHz groups |
| div_pci | output | DIV_W | Test-clock divider for PCI outputs |
| div_usb | output | DIV_W | Test-clock divider for USB/DOT outputs |
| div_ref | output | DIV_W | Test-clock divider for reference output |
| vco_en | output | 1 | VCO enable |
| out_en | output | 1 | Clock output enable |

## Verification
The bench runs all eight combinations of CPU select and the four level codes, each paired with a multiplier value. This separates the VCO-sourced modes from the external-input modes, the floating test mode from the divided test-clock mode, and the undefined code 2'b11 from the low and high codes. In every case the straps present before the strobe falls are the inverse of those present during the capture edge, which tells a capture at the correct edge from a capture one edge early. After each capture the strobe is toggled and the straps are inverted, so a design that re-samples shows up as changed held values. A reset in the middle of the lock wait, with the strobe held high afterwards, shows whether the sequence truly restarts from waiting.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_VCO    = 2'd2,
    ST_RUN    = 2'd3
  } seq_st_e;

  typedef enum logic [2:0] {
    OPM_NONE   = 3'd0,
    OPM_VCO100 = 3'd1,
    OPM_VCO133 = 3'd2,
    OPM_EXT100 = 3'd3,
    OPM_EXT133 = 3'd4,
    OPM_HIZ    = 3'd5,
    OPM_TCLK   = 3'd6
  } opmode_e;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_HIGH = 2'b10;

  typedef struct packed {
    logic       cpu;
    logic [1:0] lvl;
    logic       mult;
  } strap_t;

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= async_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import clkseq_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic pg_low,
  output logic capture,
  output logic vco_en,
  output logic out_en
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  seq_st_e        st, st_nx;
  logic [CW-1:0]  lock_cnt;

  assign capture = (st == ST_WAIT) && pg_low;

  always_comb begin
    st_nx = st;
    case (st)
      ST_WAIT:   if (pg_low) st_nx = ST_SAMPLE;
      ST_SAMPLE: st_nx = ST_VCO;
      ST_VCO:    if (lock_cnt == LAST) st_nx = ST_RUN;
      ST_RUN:    st_nx = ST_RUN;
      default:   st_nx = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_WAIT;
      lock_cnt <= '0;
      vco_en   <= 1'b0;
      out_en   <= 1'b0;
    end else begin
      st       <= st_nx;
      lock_cnt <= (st == ST_VCO) ? lock_cnt + CW'(1) : '0;
      vco_en   <= (st_nx == ST_VCO) || (st_nx == ST_RUN);
      out_en   <= (st_nx == ST_RUN);
    end
  end

  // checker-side count of cycles spent with the VCO on and outputs off
  int unsigned vco_only_cycles;
  always_ff @(posedge clk) begin
    if (rst)                   vco_only_cycles <= 0;
    else if (vco_en && !out_en) vco_only_cycles <= vco_only_cycles + 1;
  end

  // R6: outputs only with VCO running
  p_out_needs_vco_r6: assert property (@(posedge clk) disable iff (rst)
    out_en |-> vco_en);

  // R6: lock wait length
  p_lock_wait_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_en) |-> (vco_only_cycles == LOCK_CYCLES));

  // R4: no return to waiting without reset
  p_no_rewait_r4: assert property (@(posedge clk) disable iff (rst)
    (st != ST_WAIT) |=> (st != ST_WAIT));

  // R5: VCO stays on once started
  p_vco_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    vco_en |=> vco_en);
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import clkseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cap,
  input  logic       cpu_in,
  input  logic [1:0] lvl_in,
  input  logic       mult_in,
  output strap_t     q,
  output logic       valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      valid <= 1'b0;
    end else if (cap) begin
      q.cpu  <= cpu_in;
      q.lvl  <= lvl_in;
      q.mult <= mult_in;
      valid  <= 1'b1;
    end
  end

  // R3: the sequencer requests a capture only once
  p_single_capture_r3: assert property (@(posedge clk) disable iff (rst)
    cap |-> !valid);

  // R4: held straps never move after capture
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    valid |=> (valid && $stable(q)));
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import clkseq_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  strap_t           s,
  output logic [2:0]       op,
  output logic             cpu_133,
  output logic             ext66,
  output logic             hiz,
  output logic [DIV_W-1:0] d_cpu,
  output logic [DIV_W-1:0] d_66,
  output logic [DIV_W-1:0] d_pci,
  output logic [DIV_W-1:0] d_usb,
  output logic [DIV_W-1:0] d_ref
);
  opmode_e op_nx;
  logic    is_mid;

  // codes 01 and 11 both count as the middle level
  assign is_mid = s.lvl[0];

  always_comb begin
    if (!valid)                 op_nx = OPM_NONE;
    else if (is_mid)            op_nx = s.cpu ? OPM_TCLK   : OPM_HIZ;
    else if (s.lvl == LVL_HIGH) op_nx = s.cpu ? OPM_EXT133 : OPM_EXT100;
    else                        op_nx = s.cpu ? OPM_VCO133 : OPM_VCO100;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op      <= OPM_NONE;
      cpu_133 <= 1'b0;
      ext66   <= 1'b0;
      hiz     <= 1'b0;
      d_cpu   <= '0;
      d_66    <= '0;
      d_pci   <= '0;
      d_usb   <= '0;
      d_ref   <= '0;
    end else begin
      op      <= op_nx;
      cpu_133 <= (op_nx == OPM_VCO133) || (op_nx == OPM_EXT133);
      ext66   <= (op_nx == OPM_EXT100) || (op_nx == OPM_EXT133);
      hiz     <= (op_nx == OPM_HIZ);
      if (op_nx == OPM_TCLK) begin
        d_cpu <= DIV_W'(2);
        d_66  <= DIV_W'(4);
        d_pci <= DIV_W'(8);
        d_usb <= DIV_W'(2);
        d_ref <= DIV_W'(1);
      end else begin
        d_cpu <= '0;
        d_66  <= '0;
        d_pci <= '0;
        d_usb <= '0;
        d_ref <= '0;
      end
    end
  end

  // R8/R9: floating, test-clock and external-source modes exclude each other
  p_mode_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hiz, (d_cpu != '0), ext66}));

  // R1: no mode decoded before straps exist
  p_none_before_valid_r1: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (op == 3'd0));
endmodule

// File: rtl/clkgen_powerup_seq.sv
module clkgen_powerup_seq
  import clkseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYCLES = 1024,
  parameter int DIV_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwrgd_n,
  input  logic             cpu_sel,
  input  logic [1:0]       mode_lvl,
  input  logic             mult_sel,
  output logic             cpu_sel_q,
  output logic [1:0]       mode_lvl_q,
  output logic             mult_q,
  output logic             straps_valid,
  output logic [2:0]       op_mode,
  output logic             cpu_133,
  output logic             ext66_src,
  output logic             out_hiz,
  output logic [DIV_W-1:0] div_cpu,
  output logic [DIV_W-1:0] div_66,
  output logic [DIV_W-1:0] div_pci,
  output logic [DIV_W-1:0] div_usb,
  output logic [DIV_W-1:0] div_ref,
  output logic             vco_en,
  output logic             out_en
);
  logic   pg_sync_n;
  logic   cap;
  strap_t held;

  pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_n (pwrgd_n),
    .sync_n  (pg_sync_n)
  );

  seq_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .pg_low  (!pg_sync_n),
    .capture (cap),
    .vco_en  (vco_en),
    .out_en  (out_en)
  );

  strap_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .cap     (cap),
    .cpu_in  (cpu_sel),
    .lvl_in  (mode_lvl),
    .mult_in (mult_sel),
    .q       (held),
    .valid   (straps_valid)
  );

  mode_decode #(.DIV_W(DIV_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .valid   (straps_valid),
    .s       (held),
    .op      (op_mode),
    .cpu_133 (cpu_133),
    .ext66   (ext66_src),
    .hiz     (out_hiz),
    .d_cpu   (div_cpu),
    .d_66    (div_66),
    .d_pci   (div_pci),
    .d_usb   (div_usb),
    .d_ref   (div_ref)
  );

  assign cpu_sel_q  = held.cpu;
  assign mode_lvl_q = held.lvl;
  assign mult_q     = held.mult;

  // R5: VCO starts only after straps are held
  p_vco_after_straps_r5: assert property (@(posedge clk) disable iff (rst)
    vco_en |-> straps_valid);
endmodule

// File: tb/clkgen_powerup_seq_tb.sv
module clkgen_powerup_seq_tb;
  localparam int SYNC = 2;
  localparam int LOCK = 12;
  localparam int DW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwrgd_n = 1'b1;
  logic cpu_sel = 1'b0;
  logic [1:0] mode_lvl = 2'b00;
  logic mult_sel = 1'b0;
  logic cpu_sel_q, mult_q, straps_valid, cpu_133, ext66_src, out_hiz, vco_en, out_en;
  logic [1:0] mode_lvl_q;
  logic [2:0] op_mode;
  logic [DW-1:0] div_cpu, div_66, div_pci, div_usb, div_ref;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  clkgen_powerup_seq #(.SYNC_STAGES(SYNC), .LOCK_CYCLES(LOCK), .DIV_W(DW)) u_dut (
    .clk(clk), .rst(rst), .pwrgd_n(pwrgd_n), .cpu_sel(cpu_sel), .mode_lvl(mode_lvl),
    .mult_sel(mult_sel), .cpu_sel_q(cpu_sel_q), .mode_lvl_q(mode_lvl_q), .mult_q(mult_q),
    .straps_valid(straps_valid), .op_mode(op_mode), .cpu_133(cpu_133), .ext66_src(ext66_src),
    .out_hiz(out_hiz), .div_cpu(div_cpu), .div_66(div_66), .div_pci(div_pci),
    .div_usb(div_usb), .div_ref(div_ref), .vco_en(vco_en), .out_en(out_en)
  );

  typedef struct {
    logic [2:0] op;
    logic       c133, ext, hiz;
    logic [DW-1:0] dc, d66, dp, du, dr;
    string      tag;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  function automatic exp_t model(input logic cpu, input logic [1:0] lvl);
    exp_t e;
    e.dc = '0; e.d66 = '0; e.dp = '0; e.du = '0; e.dr = '0;
    e.c133 = 1'b0; e.ext = 1'b0; e.hiz = 1'b0;
    if (lvl == 2'b01 || lvl == 2'b11) begin
      e.tag = (lvl == 2'b11) ? "R10" : (cpu ? "R9" : "R8");
      if (cpu) begin
        e.op = 3'd6; e.dc = 2; e.d66 = 4; e.dp = 8; e.du = 2; e.dr = 1;
      end else begin
        e.op = 3'd5; e.hiz = 1'b1;
      end
    end else begin
      e.tag  = "R7";
      e.c133 = cpu;
      e.ext  = (lvl == 2'b10);
      e.op   = (lvl == 2'b10) ? (cpu ? 3'd4 : 3'd3) : (cpu ? 3'd2 : 3'd1);
    end
    return e;
  endfunction

  // monitor: measure lock wait and compare decoded mode when outputs turn on
  int  vco_cnt = 0;
  logic out_prev = 1'b0;
  always @(negedge clk) begin
    if (rst || !vco_en) vco_cnt = 0;
    else if (!out_en) vco_cnt++;
    if (!rst && out_en && !out_prev) begin
      chk("R6", "lock wait cycles", vco_cnt, LOCK);
      if (sb.size() == 0) begin
        chk("R6", "unexpected output enable", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "op_mode", op_mode, e.op);
        chk(e.tag, "cpu_133", cpu_133, e.c133);
        chk(e.tag, "ext66_src", ext66_src, e.ext);
        chk(e.tag, "out_hiz", out_hiz, e.hiz);
        chk(e.tag, "div_cpu", div_cpu, e.dc);
        chk(e.tag, "div_66", div_66, e.d66);
        chk(e.tag, "div_pci", div_pci, e.dp);
        chk(e.tag, "div_usb", div_usb, e.du);
        chk(e.tag, "div_ref", div_ref, e.dr);
      end
    end
    out_prev = rst ? 1'b0 : out_en;
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pwrgd_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "vco_en in reset", vco_en, 0);
    chk("R1", "out_en in reset", out_en, 0);
    chk("R1", "straps_valid in reset", straps_valid, 0);
    chk("R1", "op_mode in reset", op_mode, 0);
    rst = 1'b0;
  endtask

  task automatic run_case(input logic cpu, input logic [1:0] lvl, input logic mult);
    exp_t e;
    do_reset();
    cpu_sel = ~cpu; mode_lvl = ~lvl; mult_sel = ~mult;
    repeat (5) @(negedge clk);
    chk("R2", "straps_valid while strobe high", straps_valid, 0);
    chk("R2", "vco_en while strobe high", vco_en, 0);
    e = model(cpu, lvl);
    sb.push_back(e);
    cpu_sel = cpu; mode_lvl = lvl; mult_sel = mult; pwrgd_n = 1'b0;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    chk("R3", "straps_valid one edge early", straps_valid, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3", "straps_valid", straps_valid, 1);
    chk("R3", "cpu_sel_q", cpu_sel_q, cpu);
    chk("R3", "mode_lvl_q", mode_lvl_q, lvl);
    chk("R3", "mult_q", mult_q, mult);
    chk("R5", "vco_en before start", vco_en, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R5", "vco_en", vco_en, 1);
    chk(e.tag, "op_mode with vco_en", op_mode, e.op);
    pwrgd_n = 1'b1; cpu_sel = ~cpu; mode_lvl = ~lvl; mult_sel = ~mult;
    repeat (LOCK + 4) @(negedge clk);
    pwrgd_n = 1'b0;
    repeat (SYNC + 4) @(negedge clk);
    chk("R4", "cpu_sel_q after strobe toggle", cpu_sel_q, cpu);
    chk("R4", "mode_lvl_q after strobe toggle", mode_lvl_q, lvl);
    chk("R4", "mult_q after strobe toggle", mult_q, mult);
    chk("R4", "op_mode after strobe toggle", op_mode, e.op);
    chk("R4", "out_en held", out_en, 1);
    chk("R5", "vco_en held", vco_en, 1);
    chk("R6", "scoreboard drained", sb.size(), 0);
  endtask

  initial begin
    #(20 * 150000);
    chk("R6", "watchdog expired", 1, 0);
    finish_up();
  end

  initial begin
    run_case(1'b0, 2'b00, 1'b0);
    run_case(1'b1, 2'b00, 1'b1);
    run_case(1'b0, 2'b10, 1'b1);
    run_case(1'b1, 2'b10, 1'b0);
    run_case(1'b0, 2'b01, 1'b0);
    run_case(1'b1, 2'b01, 1'b1);
    run_case(1'b0, 2'b11, 1'b1);
    run_case(1'b1, 2'b11, 1'b0);

    // R11: reset in the middle of the lock wait
    do_reset();
    cpu_sel = 1'b1; mode_lvl = 2'b00; mult_sel = 1'b1; pwrgd_n = 1'b0;
    repeat (SYNC + 4) @(negedge clk);
    chk("R11", "vco_en before mid reset", vco_en, 1);
    chk("R11", "out_en before mid reset", out_en, 0);
    rst = 1'b1; pwrgd_n = 1'b1;
    @(negedge clk);
    chk("R11", "vco_en after mid reset", vco_en, 0);
    chk("R11", "straps_valid after mid reset", straps_valid, 0);
    rst = 1'b0;
    repeat (LOCK + 6) @(negedge clk);
    chk("R11", "no capture with strobe high", straps_valid, 0);
    chk("R11", "vco_en stays low", vco_en, 0);
    chk("R11", "out_en stays low", out_en, 0);

    run_case(1'b1, 2'b10, 1'b1);
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule